// File: doc/BRIEF.md
# Link-Side Transmit Sequencer

This block sits on the link side of a synchronous PHY-to-link interface and runs on the PHY's system clock. The two parties share a 2-bit control bus and an 8-bit data bus. The block watches the control bus until the PHY hands the interface over. It then drives both buses for one packet and gives them back. The bidirectional buses appear here as separate PHY-driven inputs, link-driven outputs and a single output enable that covers both link-driven buses.

After takeover the link may send one idle cycle and then a bounded run of hold cycles while it waits for data. It streams bytes from a ready/valid byte source with a last-byte flag. It closes the packet with idle (done) or hold (another packet follows on the same bus tenure). When multispeed concatenation is enabled, the hold cycle carries the speed code of the next packet. A concatenation the serial bus cannot carry is refused and flagged. Every tenure ends with exactly one extra idle cycle before the outputs are released.

Top module: `link_tx_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, `lnk_oe`, `tx_ready` and `tx_err` are low.
- R2: The block takes the buses only in the cycle right after `phy_ctl` showed grant (11) and then idle (00) on consecutive cycles. The first link-owned cycle directly follows that idle cycle, and no other pattern causes a takeover.
- R3: If a byte is offered during the handover cycle, the first owned cycle already carries transmit (10). Otherwise the first owned cycle is a single idle (00), followed by hold (01) until a byte is offered.
- R4: Hold runs never exceed `MAX_HOLD` (47) consecutive cycles. A byte offered after exactly 47 holds is still transmitted. If none is offered, the next cycle is an idle terminator (null packet).
- R5: A byte accepted while `tx_valid` and `tx_ready` are both high appears on `lnk_data`, with `lnk_ctl` = transmit (10), in the next cycle. Bytes keep the order in which they were accepted.
- R6: When the last byte (`tx_last` = 1) is accepted with `cat_req` low, the cycle after that byte on the bus is an idle terminator.
- R7: When the last byte is accepted with `cat_req` high and the request is legal, the terminator is hold (01). Its data is the speed code of `cat_spd` (0 = S100 → 00h, 1 = S200 → 40h, 2 = S400 → 50h) if `ms_en` is high, and 00h if it is low.
- R8: With `ms_en` high, a request for S100 while `pkt_spd` is above S100, or a request with the reserved code 3, is refused. The terminator is then idle, and `tx_err` is high for that one cycle only.
- R9: After any terminator, exactly one more idle cycle is driven and then `lnk_oe` drops. Whenever `lnk_oe` is low, `lnk_ctl` and `lnk_data` are zero, and the link never drives 11.
- R10: If `tx_valid` is low in a cycle after a non-last byte, the packet ends with an idle terminator and `tx_err` is high for that one cycle.
- R11: In the first cycle after release, `phy_ctl` is ignored: a grant there cannot start a takeover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY system clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_ctl | input | 2 | Control bus as driven by the PHY |
| lnk_ctl | output | 2 | Control bus as driven by the link |
| lnk_data | output | 8 | Data bus as driven by the link |
| lnk_oe | output | 1 | Link drives both buses while high |
| ms_en | input | 1 | Multispeed concatenation enabled |
| pkt_spd | input | 2 | Speed of the packet being sent (0 S100, 1 S200, 2 S400) |
| tx_valid | input | 1 | Byte source has a byte |
| tx_byte | input | 8 | Byte to send |
| tx_last | input | 1 | Offered byte is the last of the packet |
| tx_ready | output | 1 | Block accepts the offered byte this cycle |
| cat_req | input | 1 | Concatenate another packet, sampled with the last byte |
| cat_spd | input | 2 | Speed of the concatenated packet, same coding as `pkt_spd` |
| tx_err | output | 1 | One-cycle pulse on a refused concatenation or an underrun |

## Verification
The assertions watch the handover and release rules on every cycle. They check that a takeover only follows grant-then-idle and that a release only follows an idle. They also check that no hold run passes the limit, that an accepted byte shows up with transmit one cycle later, that an error always sits on an idle terminator, and that the buses are quiet while released. Only the bench's scenarios can show which terminator and speed code a given concatenation request produces, the exact 47-hold boundary, the null packet, the underrun path and the ignored grant right after release.

// File: rtl/ltx_pkg.sv
`timescale 1ns/1ps
package ltx_pkg;

    localparam int LTX_DW = 8;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'b00,
        CTL_HOLD  = 2'b01,
        CTL_XMIT  = 2'b10,
        CTL_GRANT = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        SPD_S100 = 2'd0,
        SPD_S200 = 2'd1,
        SPD_S400 = 2'd2,
        SPD_RSV  = 2'd3
    } spd_e;

    typedef enum logic [2:0] {
        ST_WAIT,   // released, watching for a grant
        ST_PRE,    // bus shows the optional idle
        ST_HOLD,   // bus shows a hold
        ST_DATA,   // bus shows a non-last byte
        ST_LASTB,  // bus shows the last byte
        ST_TERM,   // bus shows the terminator
        ST_TAIL,   // bus shows the trailing idle
        ST_COOL    // released, PHY input ignored
    } st_e;

    typedef struct packed {
        logic              oe;
        ctl_e              ctl;
        logic [LTX_DW-1:0] data;
        logic              err;
    } bus_t;

    typedef struct packed {
        logic              hold;
        logic [LTX_DW-1:0] code;
        logic              refuse;
    } term_t;

    localparam bus_t BUS_OFF = '{oe: 1'b0, ctl: CTL_IDLE, data: '0, err: 1'b0};

    function automatic logic [LTX_DW-1:0] spd_code(spd_e s);
        case (s)
            SPD_S200: spd_code = LTX_DW'(8'h40);
            SPD_S400: spd_code = LTX_DW'(8'h50);
            default:  spd_code = '0;
        endcase
    endfunction

    function automatic logic concat_legal(spd_e cur, spd_e nxt);
        concat_legal = (nxt != SPD_RSV) && !((nxt == SPD_S100) && (cur != SPD_S100));
    endfunction

endpackage

// File: rtl/ltx_grant_det.sv
`timescale 1ns/1ps
module ltx_grant_det
    import ltx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic [1:0] phy_ctl,
    output logic       take
);
    logic saw_q;

    always_ff @(posedge clk) begin
        if (rst) saw_q <= 1'b0;
        else     saw_q <= arm && (phy_ctl == CTL_GRANT);
    end

    assign take = arm && saw_q && (phy_ctl == CTL_IDLE);
endmodule

// File: rtl/ltx_hold_ctr.sv
`timescale 1ns/1ps
module ltx_hold_ctr #(
    parameter int MAX_HOLD = 47
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    output logic at_max
);
    localparam int CW = $clog2(MAX_HOLD + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !inc) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign at_max = (cnt_q == CW'(MAX_HOLD));
endmodule

// File: rtl/ltx_term_sel.sv
`timescale 1ns/1ps
module ltx_term_sel
    import ltx_pkg::*;
(
    input  logic  req,
    input  logic  ms_en,
    input  spd_e  cur,
    input  spd_e  nxt,
    output term_t dec
);
    always_comb begin
        dec = '{hold: 1'b0, code: '0, refuse: 1'b0};
        if (req) begin
            if (ms_en && !concat_legal(cur, nxt)) begin
                dec.refuse = 1'b1;
            end else begin
                dec.hold = 1'b1;
                dec.code = ms_en ? spd_code(nxt) : '0;
            end
        end
    end
endmodule

// File: rtl/link_tx_seq.sv
`timescale 1ns/1ps
module link_tx_seq
    import ltx_pkg::*;
#(
    parameter int MAX_HOLD = 47
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        phy_ctl,
    output logic [1:0]        lnk_ctl,
    output logic [LTX_DW-1:0] lnk_data,
    output logic              lnk_oe,
    input  logic              ms_en,
    input  logic [1:0]        pkt_spd,
    input  logic              tx_valid,
    input  logic [LTX_DW-1:0] tx_byte,
    input  logic              tx_last,
    output logic              tx_ready,
    input  logic              cat_req,
    input  logic [1:0]        cat_spd,
    output logic              tx_err
);
    st_e   st_q, st_d;
    bus_t  out_q, out_d;
    term_t dec, dec_q;
    logic  take, arm, hold_inc, at_max, accept;
    st_e   after_byte;

    assign arm = (st_q == ST_WAIT);

    ltx_grant_det u_gnt (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm),
        .phy_ctl (phy_ctl),
        .take    (take)
    );

    ltx_hold_ctr #(.MAX_HOLD(MAX_HOLD)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .inc    (hold_inc),
        .at_max (at_max)
    );

    ltx_term_sel u_term (
        .req   (cat_req),
        .ms_en (ms_en),
        .cur   (spd_e'(pkt_spd)),
        .nxt   (spd_e'(cat_spd)),
        .dec   (dec)
    );

    assign tx_ready   = take || (st_q inside {ST_PRE, ST_HOLD, ST_DATA});
    assign accept     = tx_ready && tx_valid;
    assign after_byte = tx_last ? ST_LASTB : ST_DATA;

    always_comb begin
        st_d     = st_q;
        out_d    = BUS_OFF;
        hold_inc = 1'b0;
        case (st_q)
            ST_WAIT: begin
                if (take) begin
                    out_d.oe = 1'b1;
                    if (tx_valid) begin
                        out_d.ctl  = CTL_XMIT;
                        out_d.data = tx_byte;
                        st_d       = after_byte;
                    end else begin
                        st_d = ST_PRE;
                    end
                end
            end
            ST_PRE, ST_HOLD: begin
                out_d.oe = 1'b1;
                if (tx_valid) begin
                    out_d.ctl  = CTL_XMIT;
                    out_d.data = tx_byte;
                    st_d       = after_byte;
                end else if ((st_q == ST_HOLD) && at_max) begin
                    st_d = ST_TERM;
                end else begin
                    out_d.ctl = CTL_HOLD;
                    hold_inc  = 1'b1;
                    st_d      = ST_HOLD;
                end
            end
            ST_DATA: begin
                out_d.oe = 1'b1;
                if (tx_valid) begin
                    out_d.ctl  = CTL_XMIT;
                    out_d.data = tx_byte;
                    st_d       = after_byte;
                end else begin
                    out_d.err = 1'b1;
                    st_d      = ST_TERM;
                end
            end
            ST_LASTB: begin
                out_d.oe   = 1'b1;
                out_d.ctl  = dec_q.hold ? CTL_HOLD : CTL_IDLE;
                out_d.data = dec_q.code;
                out_d.err  = dec_q.refuse;
                hold_inc   = dec_q.hold;
                st_d       = ST_TERM;
            end
            ST_TERM: begin
                out_d.oe = 1'b1;
                st_d     = ST_TAIL;
            end
            ST_TAIL: st_d = ST_COOL;
            ST_COOL: st_d = ST_WAIT;
            default: st_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_WAIT;
            out_q <= BUS_OFF;
            dec_q <= '{hold: 1'b0, code: '0, refuse: 1'b0};
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
            if (accept && tx_last) dec_q <= dec;
        end
    end

    assign lnk_oe   = out_q.oe;
    assign lnk_ctl  = out_q.ctl;
    assign lnk_data = out_q.data;
    assign tx_err   = out_q.err;
endmodule

// File: rtl/ltx_checker.sv
`timescale 1ns/1ps
module ltx_checker
    import ltx_pkg::*;
#(
    parameter int MAX_HOLD = 47
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        phy_ctl,
    input logic [1:0]        lnk_ctl,
    input logic [LTX_DW-1:0] lnk_data,
    input logic              lnk_oe,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [LTX_DW-1:0] tx_byte,
    input logic              tx_err
);
    localparam int RW = $clog2(MAX_HOLD + 2);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else if (lnk_oe && (lnk_ctl == CTL_HOLD)) begin
            if (run_q < RW'(MAX_HOLD + 1)) run_q <= run_q + 1'b1;
        end else run_q <= '0;
    end

    assert_takeover_after_grant_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(lnk_oe) |-> ($past(phy_ctl) == 2'b00 && $past(phy_ctl, 2) == 2'b11));

    assert_hold_limit_R4: assert property (@(posedge clk) disable iff (rst)
        run_q <= RW'(MAX_HOLD));

    assert_byte_forward_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> (lnk_oe && lnk_ctl == 2'b10 && lnk_data == $past(tx_byte)));

    assert_err_on_idle_R8: assert property (@(posedge clk) disable iff (rst)
        tx_err |-> (lnk_oe && lnk_ctl == 2'b00));

    assert_release_after_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(lnk_oe) |-> ($past(lnk_ctl) == 2'b00 && $past(lnk_ctl, 2) inside {2'b00, 2'b01}));

    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (rst)
        !lnk_oe |-> (lnk_ctl == 2'b00 && lnk_data == '0));

    assert_never_grant_code_R9: assert property (@(posedge clk) disable iff (rst)
        lnk_oe |-> (lnk_ctl != 2'b11));

    assert_no_instant_retake_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(lnk_oe) |=> !lnk_oe);
endmodule

bind link_tx_seq ltx_checker #(.MAX_HOLD(MAX_HOLD)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .phy_ctl  (phy_ctl),
    .lnk_ctl  (lnk_ctl),
    .lnk_data (lnk_data),
    .lnk_oe   (lnk_oe),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_byte  (tx_byte),
    .tx_err   (tx_err)
);

// File: tb/sim_link_tx_seq.sv
`timescale 1ns/1ps
module sim_link_tx_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] phy_ctl = 2'b00;
    logic [1:0] lnk_ctl;
    logic [7:0] lnk_data;
    logic       lnk_oe;
    logic       ms_en = 1'b0;
    logic [1:0] pkt_spd = 2'd0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic       cat_req = 1'b0;
    logic [1:0] cat_spd = 2'd0;
    logic       tx_err;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    link_tx_seq #(.MAX_HOLD(47)) u0 (
        .clk(clk), .rst(rst), .phy_ctl(phy_ctl), .lnk_ctl(lnk_ctl), .lnk_data(lnk_data),
        .lnk_oe(lnk_oe), .ms_en(ms_en), .pkt_spd(pkt_spd), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .tx_last(tx_last), .tx_ready(tx_ready), .cat_req(cat_req),
        .cat_spd(cat_spd), .tx_err(tx_err)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_bus(string req, logic oe, logic [1:0] c, logic [7:0] d, logic e);
        check(req, "oe", 32'(lnk_oe), 32'(oe));
        check(req, "ctl", 32'(lnk_ctl), 32'(c));
        check(req, "data", 32'(lnk_data), 32'(d));
        check(req, "err", 32'(tx_err), 32'(e));
    endtask

    task automatic quiet_inputs();
        tx_valid = 1'b0; tx_last = 1'b0; tx_byte = 8'h00; cat_req = 1'b0; phy_ctl = 2'b00;
    endtask

    // grant cycle, then leaves phy_ctl at idle for the handover cycle
    task automatic grant();
        phy_ctl = 2'b11;
        tick();
        phy_ctl = 2'b00;
    endtask

    // trailing idle, release, then the ignore cycle so the next grant counts
    task automatic tail_and_settle(string req);
        quiet_inputs();
        tick(); expect_bus(req, 1'b1, 2'b00, 8'h00, 1'b0);
        tick(); expect_bus(req, 1'b0, 2'b00, 8'h00, 1'b0);
        tick();
    endtask

    task automatic t_reset();
        rst = 1'b1; phy_ctl = 2'b11; tx_valid = 1'b1;
        repeat (3) tick();
        check("R1", "oe in reset", 32'(lnk_oe), 0);
        check("R1", "ready in reset", 32'(tx_ready), 0);
        check("R1", "err in reset", 32'(tx_err), 0);
        quiet_inputs();
        rst = 1'b0;
        tick();
        check("R1", "oe after reset", 32'(lnk_oe), 0);
        check("R1", "ready after reset", 32'(tx_ready), 0);
        // idle only, and grant followed by hold: no takeover (R2)
        repeat (2) tick();
        phy_ctl = 2'b11; tick();
        phy_ctl = 2'b01; #1;
        check("R2", "ready without idle after grant", 32'(tx_ready), 0);
        tick(); check("R2", "oe without idle after grant", 32'(lnk_oe), 0);
        phy_ctl = 2'b00; tick(); check("R2", "oe stays low", 32'(lnk_oe), 0);
    endtask

    task automatic t_basic();
        grant();
        tx_valid = 1'b1; tx_byte = 8'hA1; tx_last = 1'b0; #1;
        check("R5", "ready in handover cycle", 32'(tx_ready), 1);
        tick(); expect_bus("R3", 1'b1, 2'b10, 8'hA1, 1'b0);
        tx_byte = 8'hA2; tx_last = 1'b1;
        tick(); expect_bus("R5", 1'b1, 2'b10, 8'hA2, 1'b0);
        quiet_inputs();
        tick(); expect_bus("R6", 1'b1, 2'b00, 8'h00, 1'b0);
        tail_and_settle("R9");
    endtask

    task automatic t_holds(int n_hold);
        grant();
        tick(); expect_bus("R3", 1'b1, 2'b00, 8'h00, 1'b0);
        for (int i = 0; i < n_hold; i++) begin
            tick(); expect_bus("R4", 1'b1, 2'b01, 8'h00, 1'b0);
        end
        tx_valid = 1'b1; tx_byte = 8'h5C; tx_last = 1'b1;
        tick(); expect_bus("R4", 1'b1, 2'b10, 8'h5C, 1'b0);
        quiet_inputs();
        tick(); expect_bus("R6", 1'b1, 2'b00, 8'h00, 1'b0);
        tail_and_settle("R9");
    endtask

    task automatic t_null();
        grant();
        tick(); expect_bus("R3", 1'b1, 2'b00, 8'h00, 1'b0);
        for (int i = 0; i < 47; i++) begin
            tick(); expect_bus("R4", 1'b1, 2'b01, 8'h00, 1'b0);
        end
        tick(); expect_bus("R4", 1'b1, 2'b00, 8'h00, 1'b0);
        tail_and_settle("R9");
    endtask

    task automatic t_concat(string req, logic ms, logic [1:0] cur, logic [1:0] nxt,
                            logic [1:0] exp_ctl, logic [7:0] exp_data, logic exp_err);
        ms_en = ms; pkt_spd = cur;
        grant();
        tx_valid = 1'b1; tx_byte = 8'h3E; tx_last = 1'b1; cat_req = 1'b1; cat_spd = nxt;
        tick(); expect_bus(req, 1'b1, 2'b10, 8'h3E, 1'b0);
        quiet_inputs();
        tick(); expect_bus(req, 1'b1, exp_ctl, exp_data, exp_err);
        tail_and_settle("R9");
        ms_en = 1'b0;
    endtask

    task automatic t_underrun();
        grant();
        tx_valid = 1'b1; tx_byte = 8'h21; tx_last = 1'b0;
        tick(); expect_bus("R5", 1'b1, 2'b10, 8'h21, 1'b0);
        quiet_inputs();
        tick(); expect_bus("R10", 1'b1, 2'b00, 8'h00, 1'b1);
        tail_and_settle("R10");
    endtask

    task automatic t_ignore_after_release();
        grant();
        tx_valid = 1'b1; tx_byte = 8'h77; tx_last = 1'b1;
        tick(); expect_bus("R5", 1'b1, 2'b10, 8'h77, 1'b0);
        quiet_inputs();
        tick(); expect_bus("R6", 1'b1, 2'b00, 8'h00, 1'b0);
        tick(); expect_bus("R9", 1'b1, 2'b00, 8'h00, 1'b0);
        tick(); expect_bus("R9", 1'b0, 2'b00, 8'h00, 1'b0);
        phy_ctl = 2'b11;
        tick(); check("R11", "oe after early grant", 32'(lnk_oe), 0);
        phy_ctl = 2'b00; tx_valid = 1'b1; #1;
        check("R11", "ready after early grant", 32'(tx_ready), 0);
        tick(); check("R11", "no takeover", 32'(lnk_oe), 0);
        quiet_inputs();
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_holds(3);
        t_holds(47);
        t_null();
        t_concat("R7", 1'b1, 2'd1, 2'd2, 2'b01, 8'h50, 1'b0);
        t_concat("R7", 1'b1, 2'd1, 2'd1, 2'b01, 8'h40, 1'b0);
        t_concat("R7", 1'b1, 2'd0, 2'd0, 2'b01, 8'h00, 1'b0);
        t_concat("R7", 1'b0, 2'd2, 2'd0, 2'b01, 8'h00, 1'b0);
        t_concat("R8", 1'b1, 2'd2, 2'd0, 2'b00, 8'h00, 1'b1);
        t_concat("R8", 1'b1, 2'd0, 2'd3, 2'b00, 8'h00, 1'b1);
        t_underrun();
        t_ignore_after_release();
        t_basic();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule